// File: doc/BRIEF.md
# Conflict-Free Bank Address Mapper for an NTT Coefficient Store

This block sits in front of the coefficient store of a pipelined NTT/INTT butterfly network. The store is built from two single-port bank groups of N/2 words each instead of one dual-port RAM. On every cycle the network reads one coefficient and writes back the coefficient it read a fixed number of cycles (the pipeline delay) earlier. The mapper turns a running access count, a stage number and a transform direction into a coefficient index. It then splits that index into a bank select and a row address for the read port, and replays the same pair on the write port once the pipeline delay has passed.

The visiting order inside a stage is built from the count. The count bits above bit 0 are bit-reversed and then Gray coded to form the index bits other than the butterfly bit. The butterfly bit is chosen so that the bank of the access depends only on bit 0 and on the count bit whose weight equals the delay. As long as the count advances by one per cycle, the read issued `DELAY` cycles after any read therefore lands in the opposite bank from that read's write-back. This also holds when the count wraps into the next stage or into the other direction, so no stall is ever needed. A conflict output flags any cycle where both ports are active on the same bank.

Top module: `cfa_bank_mapper`

## Requirements
- R1: A synchronous active-high reset clears `rd_vld`, `wr_vld` and `conflict` at the next rising edge, even if `acc_en` is high.
- R2: The read-port outputs are registered. One cycle after `acc_en` is sampled high, `rd_vld` is 1 and carries the mapping of the sampled inputs. After a cycle with `acc_en` low, `rd_vld` is 0.
- R3: The bank select is the XOR of all bits of the coefficient index, and the row address is index bits [LOG_N-1:1]. So (bank, row) identifies the index uniquely.
- R4: For any stage and either direction, counts 0 to N-1 visit every index from 0 to N-1 exactly once.
- R5: Counts 2k and 2k+1 of a stage address butterfly partners. Their indices differ only in bit `stage` when `acc_inv`=1, or in bit LOG_N-1-`stage` when `acc_inv`=0.
- R6: `wr_vld`, `wr_bank` and `wr_row` equal `rd_vld`, `rd_bank` and `rd_row` of exactly `DELAY` cycles earlier.
- R7: While the count advances by one (mod N) every cycle, including wraps into the next stage or direction, `rd_bank` differs from `wr_bank` whenever both ports are valid, and `conflict` stays 0.
- R8: `conflict` is 1 exactly when `rd_vld` and `wr_vld` are both 1 and `rd_bank` equals `wr_bank`.
- R9: Take the index bits other than the butterfly bit, read from low to high with that bit skipped. They equal gray(bitrev(cnt[LOG_N-1:1])), where gray(x)=x^(x>>1). The butterfly bit is set so that the bank equals cnt[0] XOR cnt[log2(DELAY)].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | An access is issued this cycle |
| acc_inv | input | 1 | 1 = inverse transform, 0 = forward transform |
| acc_stage | input | $clog2(LOG_N) | Stage number, below LOG_N |
| acc_cnt | input | LOG_N | Running access count within the stage |
| rd_vld | output | 1 | Read port active |
| rd_bank | output | 1 | Read bank group select |
| rd_row | output | LOG_N-1 | Read row address |
| wr_vld | output | 1 | Write-back port active |
| wr_bank | output | 1 | Write bank group select |
| wr_row | output | LOG_N-1 | Write row address |
| conflict | output | 1 | Both ports active on the same bank |

## Verification
The hardest case to reach is a full pipeline crossing a stage boundary, and then a direction change. At that point the write-back still belongs to the old butterfly distance while the reads already follow the new one. The bench walks every stage of a forward pass and then an inverse pass with the count running without a gap. It checks bank separation every cycle, coverage of each stage and partner pairing on every pair. A real bank clash cannot occur under contiguous counting, so the bench creates one on purpose: it reissues the same count exactly `DELAY` cycles after the first issue, with idle cycles in between.

// File: rtl/cfa_pkg.sv
package cfa_pkg;

  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_INV = 1'b1
  } xform_dir_e;

  // Position of the bit that separates butterfly partners in a stage.
  function automatic int bfly_pos(input int stage, input xform_dir_e dir, input int log_n);
    return (dir == DIR_INV) ? stage : (log_n - 1 - stage);
  endfunction

endpackage

// File: rtl/cfa_order_gen.sv
module cfa_order_gen
  import cfa_pkg::*;
#(
  parameter int LOG_N = 9,
  parameter int DELAY = 16
) (
  input  logic [LOG_N-1:0]           cnt_i,
  input  logic [$clog2(LOG_N)-1:0]   stage_i,
  input  logic                       inv_i,
  output logic [LOG_N-1:0]           idx_o
);
  // DELAY must be a power of two with 2*DELAY <= 2**LOG_N.
  localparam int FW = LOG_N - 1;
  localparam int PB = $clog2(DELAY);

  logic [FW-1:0] field;
  logic [FW-1:0] rev;
  logic [FW-1:0] gry;
  logic          flip;

  assign field = cnt_i[LOG_N-1:1];

  for (genvar i = 0; i < FW; i++) begin : g_rev
    assign rev[i] = field[FW-1-i];
  end

  assign gry  = rev ^ (rev >> 1);
  // Chosen so that the index parity equals cnt[0] ^ cnt[PB].
  assign flip = cnt_i[0] ^ cnt_i[PB] ^ (^gry);

  always_comb begin
    int pos;
    pos   = bfly_pos(int'(stage_i), xform_dir_e'(inv_i), LOG_N);
    idx_o = '0;
    for (int j = 0; j < LOG_N; j++) begin
      if (j == pos)      idx_o[j] = flip;
      else if (j < pos)  idx_o[j] = gry[j];
      else               idx_o[j] = gry[j-1];
    end
  end

endmodule

// File: rtl/cfa_bank_split.sv
module cfa_bank_split #(
  parameter int LOG_N = 9
) (
  input  logic [LOG_N-1:0] idx_i,
  output logic             bank_o,
  output logic [LOG_N-2:0] row_o
);

  assign bank_o = ^idx_i;
  assign row_o  = idx_i[LOG_N-1:1];

  // R3: bank and row together recover the index
  always_comb begin
    if (!$isunknown(idx_i)) begin
      a_r3_fields: assert ({row_o, bank_o ^ (^row_o)} == idx_i);
    end
  end

endmodule

// File: rtl/cfa_wb_delay.sv
module cfa_wb_delay #(
  parameter int W     = 9,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);

  logic [W-1:0] pipe_dat [DEPTH];
  logic [DEPTH-1:0] pipe_vld;

  // Payload carries no reset so the chain can map to shift-register cells.
  always_ff @(posedge clk) begin
    pipe_dat[0] <= dat_i;
    for (int i = 1; i < DEPTH; i++) pipe_dat[i] <= pipe_dat[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst) pipe_vld <= '0;
    else     pipe_vld <= {pipe_vld[DEPTH-2:0], vld_i};
  end

  assign vld_o = pipe_vld[DEPTH-1];
  assign dat_o = pipe_dat[DEPTH-1];

endmodule

// File: rtl/cfa_bank_mapper.sv
module cfa_bank_mapper #(
  parameter int LOG_N = 9,
  parameter int DELAY = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     acc_en,
  input  logic                     acc_inv,
  input  logic [$clog2(LOG_N)-1:0] acc_stage,
  input  logic [LOG_N-1:0]         acc_cnt,
  output logic                     rd_vld,
  output logic                     rd_bank,
  output logic [LOG_N-2:0]         rd_row,
  output logic                     wr_vld,
  output logic                     wr_bank,
  output logic [LOG_N-2:0]         wr_row,
  output logic                     conflict
);
  localparam int ROW_W = LOG_N - 1;
  localparam int STG_W = $clog2(LOG_N);
  localparam int RUN_W = $clog2(DELAY + 2);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(DELAY + 1);

  logic [LOG_N-1:0] nxt_idx;
  logic             nxt_bank;
  logic [ROW_W-1:0] nxt_row;

  cfa_order_gen #(.LOG_N(LOG_N), .DELAY(DELAY)) u_gen (
    .cnt_i   (acc_cnt),
    .stage_i (acc_stage),
    .inv_i   (acc_inv),
    .idx_o   (nxt_idx)
  );

  cfa_bank_split #(.LOG_N(LOG_N)) u_split (
    .idx_i  (nxt_idx),
    .bank_o (nxt_bank),
    .row_o  (nxt_row)
  );

  // Registered read port
  logic             rd_vld_q;
  logic             rd_bank_q;
  logic [ROW_W-1:0] rd_row_q;
  logic [LOG_N-1:0] rd_idx_q;
  logic [LOG_N-1:0] rd_cnt_q;
  logic [STG_W-1:0] rd_stage_q;
  logic             rd_inv_q;

  always_ff @(posedge clk) begin
    if (rst) rd_vld_q <= 1'b0;
    else     rd_vld_q <= acc_en;
  end

  always_ff @(posedge clk) begin
    if (acc_en) begin
      rd_bank_q  <= nxt_bank;
      rd_row_q   <= nxt_row;
      rd_idx_q   <= nxt_idx;
      rd_cnt_q   <= acc_cnt;
      rd_stage_q <= acc_stage;
      rd_inv_q   <= acc_inv;
    end
  end

  // Write-back port: the read pair replayed after the pipeline delay
  logic             wb_vld;
  logic [ROW_W:0]   wb_dat;

  cfa_wb_delay #(.W(ROW_W + 1), .DEPTH(DELAY)) u_dly (
    .clk   (clk),
    .rst   (rst),
    .vld_i (rd_vld_q),
    .dat_i ({rd_bank_q, rd_row_q}),
    .vld_o (wb_vld),
    .dat_o (wb_dat)
  );

  assign rd_vld   = rd_vld_q;
  assign rd_bank  = rd_bank_q;
  assign rd_row   = rd_row_q;
  assign wr_vld   = wb_vld;
  assign wr_bank  = wb_dat[ROW_W];
  assign wr_row   = wb_dat[ROW_W-1:0];
  assign conflict = rd_vld_q & wb_vld & (rd_bank_q == wb_dat[ROW_W]);

  // Length of the current gap-free run of reads, saturating once the
  // write-back of the run's first read has arrived.
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst || !acc_en)                                     run_q <= '0;
    else if (rd_vld_q && (acc_cnt == rd_cnt_q + LOG_N'(1))) run_q <= (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
    else                                                    run_q <= RUN_W'(1);
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!rd_vld && !wr_vld && !conflict));

  a_r5_partner: assert property (@(posedge clk) disable iff (rst)
    (rd_vld_q && $past(rd_vld_q) && rd_cnt_q[0] &&
     ($past(rd_cnt_q) + LOG_N'(1) == rd_cnt_q) &&
     $stable(rd_stage_q) && $stable(rd_inv_q))
    |-> ($countones(rd_idx_q ^ $past(rd_idx_q)) == 1));

  a_r7_no_conflict: assert property (@(posedge clk) disable iff (rst)
    (run_q == RUN_MAX) |-> (!conflict && (rd_bank != wr_bank)));

  a_r8_flag_needs_both: assert property (@(posedge clk) disable iff (rst)
    conflict |-> (rd_vld && wr_vld));

endmodule

// File: tb/cfa_bank_mapper_tb_top.sv
`timescale 1ns/1ps
module cfa_bank_mapper_tb_top;
  localparam int LOGN = 9;
  localparam int N    = 1 << LOGN;
  localparam int DLY  = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_en = 1'b0;
  logic       acc_inv = 1'b0;
  logic [3:0] acc_stage = '0;
  logic [8:0] acc_cnt = '0;
  logic       rd_vld, rd_bank, wr_vld, wr_bank, conflict;
  logic [7:0] rd_row, wr_row;

  always #10 clk = ~clk;

  cfa_bank_mapper #(.LOG_N(LOGN), .DELAY(DLY)) dut_i (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_inv(acc_inv),
    .acc_stage(acc_stage), .acc_cnt(acc_cnt),
    .rd_vld(rd_vld), .rd_bank(rd_bank), .rd_row(rd_row),
    .wr_vld(wr_vld), .wr_bank(wr_bank), .wr_row(wr_row),
    .conflict(conflict)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit sweep_on = 0;

  // {inv, stage[3:0], cnt[8:0], idx[8:0]}
  localparam logic [22:0] VEC [9] = '{
    {1'b1, 4'd0, 9'd0,   9'd0},
    {1'b1, 4'd0, 9'd1,   9'd1},
    {1'b1, 4'd0, 9'd2,   9'd384},
    {1'b1, 4'd0, 9'd16,  9'd49},
    {1'b0, 4'd0, 9'd1,   9'd256},
    {1'b0, 4'd0, 9'd2,   9'd192},
    {1'b1, 4'd3, 9'd2,   9'd384},
    {1'b1, 4'd3, 9'd511, 9'd264},
    {1'b0, 4'd8, 9'd511, 9'd257}
  };

  logic       ring_v [DLY];
  logic       ring_b [DLY];
  logic [7:0] ring_r [DLY];
  int         ptr = 0;
  logic       seen [N];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input bit en, input bit inv, input int s, input int c);
    acc_en    = en;
    acc_inv   = inv;
    acc_stage = 4'(s);
    acc_cnt   = 9'(c);
  endtask

  // One cycle; sample at the falling edge, then apply per-cycle checks.
  task automatic tick();
    @(negedge clk);
    if (rst) begin
      for (int i = 0; i < DLY; i++) begin ring_v[i] = 1'b0; ring_b[i] = 1'b0; ring_r[i] = '0; end
      ptr = 0;
      chk(!rd_vld && !wr_vld && !conflict, "R1 outputs clear in reset",
          int'({rd_vld, wr_vld, conflict}), 0);
    end else begin
      chk(wr_vld === ring_v[ptr], "R6 wr_vld replay", int'(wr_vld), int'(ring_v[ptr]));
      if (ring_v[ptr]) begin
        chk(wr_bank === ring_b[ptr] && wr_row === ring_r[ptr], "R6 wr bank/row replay",
            int'({wr_bank, wr_row}), int'({ring_b[ptr], ring_r[ptr]}));
      end
      ring_v[ptr] = rd_vld; ring_b[ptr] = rd_bank; ring_r[ptr] = rd_row;
      ptr = (ptr + 1) % DLY;
      chk(conflict === (rd_vld && wr_vld && (rd_bank == wr_bank)), "R8 conflict flag",
          int'(conflict), int'(rd_vld && wr_vld && (rd_bank == wr_bank)));
      if (sweep_on && rd_vld && wr_vld)
        chk(rd_bank != wr_bank, "R7 banks differ", int'(rd_bank), int'(!wr_bank));
    end
  endtask

  initial begin
    int prev_idx;
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // Table of hand-computed mappings
    foreach (VEC[k]) begin
      logic [8:0] e_idx;
      e_idx = VEC[k][8:0];
      drive(1'b1, VEC[k][22], int'(VEC[k][21:18]), int'(VEC[k][17:9]));
      tick();
      chk(rd_vld === 1'b1, "R2 rd_vld after issue", int'(rd_vld), 1);
      chk(rd_row === e_idx[8:1], "R9/R3 row", int'(rd_row), int'(e_idx[8:1]));
      chk(rd_bank === ^e_idx, "R3 bank parity", int'(rd_bank), int'(^e_idx));
      chk(rd_bank === (VEC[k][9] ^ VEC[k][13]), "R9 bank from count",
          int'(rd_bank), int'(VEC[k][9] ^ VEC[k][13]));
      drive(1'b0, 1'b0, 0, 0);
      tick();
      chk(rd_vld === 1'b0, "R2 rd_vld idle", int'(rd_vld), 0);
    end
    repeat (20) tick();

    // Gap-free sweep: all forward stages, then all inverse stages
    for (int i = 0; i < N; i++) seen[i] = 1'b0;
    prev_idx = 0;
    sweep_on = 1;
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < LOGN; s++) begin
        for (int c = 0; c < N; c++) begin
          int idx;
          int p;
          drive(1'b1, d[0], s, c);
          tick();
          idx = int'({rd_row, rd_bank ^ (^rd_row)});
          if (seen[idx]) chk(1'b0, "R4 index repeated", idx, -1);
          seen[idx] = 1'b1;
          p = (d == 1) ? s : (LOGN - 1 - s);
          if (c % 2 == 1)
            chk((idx ^ prev_idx) == (1 << p), "R5 partner bit", idx ^ prev_idx, 1 << p);
          else
            prev_idx = idx;
          if (c == N - 1) begin
            int cov;
            cov = 0;
            for (int i = 0; i < N; i++) begin cov += int'(seen[i]); seen[i] = 1'b0; end
            chk(cov == N, "R4 stage coverage", cov, N);
          end
        end
      end
    end
    drive(1'b0, 1'b0, 0, 0);
    repeat (20) tick();
    sweep_on = 0;

    // Forced clash: same count reissued exactly DLY cycles later
    drive(1'b1, 1'b1, 0, 0);
    tick();
    drive(1'b0, 1'b0, 0, 0);
    repeat (DLY - 1) tick();
    drive(1'b1, 1'b1, 0, 0);
    tick();
    chk(conflict === 1'b1, "R8 clash flagged", int'(conflict), 1);
    chk(wr_vld === 1'b1 && wr_bank === rd_bank, "R8 clash same bank",
        int'({wr_vld, wr_bank}), int'({1'b1, rd_bank}));
    drive(1'b0, 1'b0, 0, 0);
    repeat (DLY + 2) tick();

    // Reset in the middle of traffic
    drive(1'b1, 1'b0, 2, 5);
    tick();
    drive(1'b1, 1'b0, 2, 6);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    drive(1'b0, 1'b0, 0, 0);
    tick();
    chk(rd_vld === 1'b0 && wr_vld === 1'b0, "R1 cleared after mid-run reset",
        int'({rd_vld, wr_vld}), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule